// File: doc/BRIEF.md
# Subroutine call bus-cycle sequencer

This block is the hardwired sequencer for the subroutine-call instruction of an 8-bit processor with a 16-bit address bus. It produces the external bus pattern of the instruction cycle for cycle. A controller raises `start_i` while the opcode fetch bus cycle is running. If the fetched opcode is the call opcode, the sequencer takes control at the end of that cycle and runs six further bus cycles:

- a read of the low target byte;
- a stack read whose data is thrown away;
- two stack writes that push the return address, high byte first;
- a read of the high target byte;
- a closing opcode fetch at the new program counter.

Bus cycles are paced by the phase-two clock level `phi2_i`. This level is sampled by the fast system clock `clk_i`. A bus cycle ends on the falling phase-two edge. Read data, the start request and the opcode are all taken on that edge. The program counter and stack pointer are loaded from `pc_i` and `sp_i` on entry. They are updated in the exact bus cycles where the processor would update them, and they stay visible on `pc_o` and `sp_o`.

Top module: `jsr_sequencer`

## Requirements
- R1: After reset, `addr_o`, `pc_o` and `sp_o` are zero, `rw_n_o` is 1, and `data_oe_o`, `sync_o` and `done_o` are 0.
- R2: The sequencer starts only at a falling phase-two edge where `start_i` is 1 and `opcode_i` is 0x20, and only while idle or in the closing fetch cycle. On entry it loads the program counter with `pc_i`+1 and the stack pointer with `sp_i`. Any other opcode is ignored: the bus stays idle and `pc_o` keeps its value.
- R3: Bus cycle 2 reads at the operand address (opcode address + 1) with `sync_o` low. The data at its closing falling edge is kept as the target low byte.
- R4: Bus cycle 3 reads at stack address {0x01, SP}. Its data has no effect on any result. The program counter is incremented at the end of this cycle.
- R5: Bus cycle 4 writes the high byte of (opcode address + 2) to {0x01, SP}. The stack pointer decrements at the end of this cycle.
- R6: Bus cycle 5 writes the low byte of (opcode address + 2) to {0x01, SP-1}.
- R7: Bus cycle 6 reads at (opcode address + 2). The data at its closing falling edge becomes the target high byte, and the stack pointer decrements again.
- R8: Bus cycle 7 reads at {high byte, low byte} with `sync_o` and `done_o` high. In this cycle `pc_o` equals that target and `sp_o` equals the entry SP-2. `done_o` is high in no other cycle.
- R9: In a write cycle, `rw_n_o` is low during both phases and `data_oe_o` is high only while `phi2_i` is high. `rw_n_o` returns high only when the write cycle ends on a falling edge.
- R10: The stack pointer wraps modulo 256: entry SP 0x00 pushes to 0x0100 and then 0x01FF and leaves 0xFE. The program counter carries across byte boundaries.
- R11: A call opcode accepted at the end of the closing fetch cycle starts a new sequence immediately, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the phase-two level |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phi2_i | input | 1 | Phase-two clock level; a falling edge ends a bus cycle |
| start_i | input | 1 | An opcode fetch is in progress |
| opcode_i | input | 8 | Opcode fetched in the current cycle |
| pc_i | input | 16 | Address of the fetched opcode |
| sp_i | input | 8 | Stack pointer at entry |
| data_i | input | 8 | Read data bus |
| addr_o | output | 16 | Address bus |
| data_o | output | 8 | Write data bus |
| data_oe_o | output | 1 | Write data drive enable |
| rw_n_o | output | 1 | 1 for read, 0 for write |
| sync_o | output | 1 | Opcode fetch marker |
| done_o | output | 1 | Sequence is in its closing fetch cycle |
| pc_o | output | 16 | Program counter |
| sp_o | output | 8 | Stack pointer |

## Verification
The bench uses the default parameters: an 8-bit data width, stack page 0x01 and call opcode 0x20. With these values a start at SP 0x00 reaches the modulo-256 wrap of the stack pointer. An opcode at 0x12FE makes the return address carry into the next page. The same settings also allow a second call to chain straight out of the closing fetch cycle, and a foreign opcode to be shown to leave the bus idle.

// File: rtl/jsr_seq_pkg.sv
package jsr_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ADL     = 3'd1,
    ST_DUMMY   = 3'd2,
    ST_PUSH_HI = 3'd3,
    ST_PUSH_LO = 3'd4,
    ST_ADH     = 3'd5,
    ST_FETCH   = 3'd6
  } jsr_state_e;
endpackage

// File: rtl/jsr_phase_edge.sv
module jsr_phase_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phi2_i,
  output logic fall_o
);
  logic phi2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phi2_q <= 1'b0;
    else         phi2_q <= phi2_i;
  end

  assign fall_o = phi2_q & ~phi2_i;
endmodule

// File: rtl/jsr_fsm.sv
module jsr_fsm
  import jsr_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] CALL_OPCODE = 'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] opcode_i,
  output jsr_state_e        state_o,
  output logic              pc_load_o,
  output logic              pc_inc_o,
  output logic              sp_dec_o,
  output logic              adl_cap_o,
  output logic              tgt_load_o
);
  jsr_state_e state_q, state_d;
  logic       accept;

  assign accept = start_i && (opcode_i == CALL_OPCODE);

  always_comb begin
    state_d    = state_q;
    pc_load_o  = 1'b0;
    pc_inc_o   = 1'b0;
    sp_dec_o   = 1'b0;
    adl_cap_o  = 1'b0;
    tgt_load_o = 1'b0;
    if (fall_i) begin
      unique case (state_q)
        ST_IDLE, ST_FETCH: begin
          if (accept) begin
            state_d   = ST_ADL;
            pc_load_o = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
        ST_ADL: begin
          adl_cap_o = 1'b1;
          state_d   = ST_DUMMY;
        end
        ST_DUMMY: begin
          pc_inc_o = 1'b1;
          state_d  = ST_PUSH_HI;
        end
        ST_PUSH_HI: begin
          sp_dec_o = 1'b1;
          state_d  = ST_PUSH_LO;
        end
        ST_PUSH_LO: state_d = ST_ADH;
        ST_ADH: begin
          sp_dec_o   = 1'b1;
          tgt_load_o = 1'b1;
          state_d    = ST_FETCH;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/jsr_regs.sv
module jsr_regs #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pc_load_i,
  input  logic              pc_inc_i,
  input  logic              sp_dec_i,
  input  logic              adl_cap_i,
  input  logic              tgt_load_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] sp_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] sp_o
);
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] sp_q;
  logic [DATA_W-1:0] adl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      sp_q  <= '0;
      adl_q <= '0;
    end else begin
      if (pc_load_i)       pc_q <= pc_i + ADDR_W'(1);
      else if (tgt_load_i) pc_q <= {data_i, adl_q};
      else if (pc_inc_i)   pc_q <= pc_q + ADDR_W'(1);

      if (pc_load_i)     sp_q <= sp_i;
      else if (sp_dec_i) sp_q <= sp_q - DATA_W'(1);  // wraps modulo 2**DATA_W

      if (adl_cap_i) adl_q <= data_i;
    end
  end

  assign pc_o = pc_q;
  assign sp_o = sp_q;
endmodule

// File: rtl/jsr_bus.sv
module jsr_bus
  import jsr_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W,
  parameter logic [DATA_W-1:0] STACK_PAGE = 'h01
) (
  input  jsr_state_e        state_i,
  input  logic              phi2_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] sp_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              rw_n_o,
  output logic              sync_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] stack_addr;
  logic              wr;
  logic              fetch;

  assign stack_addr = {STACK_PAGE, sp_i};

  always_comb begin
    addr_o = pc_i;
    data_o = '0;
    wr     = 1'b0;
    fetch  = 1'b0;
    unique case (state_i)
      ST_DUMMY: addr_o = stack_addr;
      ST_PUSH_HI: begin
        addr_o = stack_addr;
        data_o = pc_i[ADDR_W-1:DATA_W];
        wr     = 1'b1;
      end
      ST_PUSH_LO: begin
        addr_o = stack_addr;
        data_o = pc_i[DATA_W-1:0];
        wr     = 1'b1;
      end
      ST_FETCH: fetch = 1'b1;
      default: ;
    endcase
  end

  // drive only in the high phase of a write cycle
  assign data_oe_o = wr & phi2_i;
  assign rw_n_o    = ~wr;
  assign sync_o    = fetch;
  assign done_o    = fetch;
endmodule

// File: rtl/jsr_sequencer.sv
module jsr_sequencer
  import jsr_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W,
  parameter logic [DATA_W-1:0] STACK_PAGE  = 'h01,
  parameter logic [DATA_W-1:0] CALL_OPCODE = 'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              phi2_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] opcode_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] sp_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              rw_n_o,
  output logic              sync_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] sp_o
);
  logic       fall;
  jsr_state_e state;
  logic       pc_load, pc_inc, sp_dec, adl_cap, tgt_load;

  jsr_phase_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phi2_i (phi2_i),
    .fall_o (fall)
  );

  jsr_fsm #(.DATA_W(DATA_W), .CALL_OPCODE(CALL_OPCODE)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fall_i     (fall),
    .start_i    (start_i),
    .opcode_i   (opcode_i),
    .state_o    (state),
    .pc_load_o  (pc_load),
    .pc_inc_o   (pc_inc),
    .sp_dec_o   (sp_dec),
    .adl_cap_o  (adl_cap),
    .tgt_load_o (tgt_load)
  );

  jsr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pc_load_i  (pc_load),
    .pc_inc_i   (pc_inc),
    .sp_dec_i   (sp_dec),
    .adl_cap_i  (adl_cap),
    .tgt_load_i (tgt_load),
    .pc_i       (pc_i),
    .sp_i       (sp_i),
    .data_i     (data_i),
    .pc_o       (pc_o),
    .sp_o       (sp_o)
  );

  jsr_bus #(.DATA_W(DATA_W), .STACK_PAGE(STACK_PAGE)) u_bus (
    .state_i   (state),
    .phi2_i    (phi2_i),
    .pc_i      (pc_o),
    .sp_i      (sp_o),
    .addr_o    (addr_o),
    .data_o    (data_o),
    .data_oe_o (data_oe_o),
    .rw_n_o    (rw_n_o),
    .sync_o    (sync_o),
    .done_o    (done_o)
  );
endmodule

// File: rtl/jsr_sequencer_chk.sv
module jsr_sequencer_chk #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W,
  parameter logic [DATA_W-1:0] STACK_PAGE = 'h01
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              phi2_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              data_oe_o,
  input logic              rw_n_o,
  input logic              sync_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic [DATA_W-1:0] sp_o
);
  logic phi2_q;
  logic fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phi2_q <= 1'b0;
    else         phi2_q <= phi2_i;
  end
  assign fall = phi2_q & ~phi2_i;

  assert_oe_in_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!rw_n_o && phi2_i));

  assert_rw_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!rw_n_o) && rw_n_o) |-> $past(fall));

  // R5 and R6: pushes go to the stack page only
  assert_push_on_stack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rw_n_o |-> (addr_o[ADDR_W-1:DATA_W] == STACK_PAGE));

  assert_fetch_at_pc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> (done_o && rw_n_o && addr_o == pc_o));

  assert_sp_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!rw_n_o) && !$stable(sp_o)) |-> (sp_o == DATA_W'($past(sp_o) - 1'b1)));
endmodule

bind jsr_sequencer jsr_sequencer_chk #(.DATA_W(DATA_W), .STACK_PAGE(STACK_PAGE)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .phi2_i    (phi2_i),
  .addr_o    (addr_o),
  .data_oe_o (data_oe_o),
  .rw_n_o    (rw_n_o),
  .sync_o    (sync_o),
  .done_o    (done_o),
  .pc_o      (pc_o),
  .sp_o      (sp_o)
);

// File: tb/tb_jsr_sequencer.sv
module tb_jsr_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phi2 = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [15:0] pc_in = '0;
  logic [7:0]  sp_in = '0;
  logic [7:0]  din = '0;
  logic [15:0] addr;
  logic [7:0]  dout;
  logic        oe, rw_n, sync, done;
  logic [15:0] pc_out;
  logic [7:0]  sp_out;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model_pc = '0;
  logic [7:0]  model_sp = '0;

  always #4 clk = ~clk;

  jsr_sequencer dut (
    .clk_i(clk), .rst_ni(rst_n), .phi2_i(phi2), .start_i(start), .opcode_i(opcode),
    .pc_i(pc_in), .sp_i(sp_in), .data_i(din), .addr_o(addr), .data_o(dout),
    .data_oe_o(oe), .rw_n_o(rw_n), .sync_o(sync), .done_o(done), .pc_o(pc_out), .sp_o(sp_out)
  );

  typedef struct {
    logic [15:0] a;
    logic        rw;
    logic        sy;
    logic        dn;
    logic        oe;
    logic        chk_d;
    logic [7:0]  d;
    logic        chk_r;
    logic [15:0] pc;
    logic [7:0]  sp;
    string       tag;
  } exp_t;

  exp_t q[$];
  event smp;

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected items and compares at each sample point
  initial begin
    forever begin
      @(smp);
      if (q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R8 scoreboard underflow: actual 0 expected 1");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "addr", addr, e.a);
        chk(e.tag, "rw_n", 16'(rw_n), 16'(e.rw));
        chk(e.tag, "sync", 16'(sync), 16'(e.sy));
        chk(e.tag, "done", 16'(done), 16'(e.dn));
        chk("R9", "data_oe", 16'(oe), 16'(e.oe));
        if (e.chk_d) chk(e.tag, "data_o", 16'(dout), 16'(e.d));
        if (e.chk_r) begin
          chk(e.tag, "pc_o", pc_out, e.pc);
          chk(e.tag, "sp_o", 16'(sp_out), 16'(e.sp));
        end
      end
    end
  end

  function automatic exp_t mk(input logic [15:0] a, input logic w, input logic f, input logic [7:0] d,
                              input logic cr, input logic [15:0] p, input logic [7:0] s, input string tag);
    exp_t e;
    e.a = a; e.rw = ~w; e.sy = f; e.dn = f; e.oe = w;
    e.chk_d = w; e.d = d; e.chk_r = cr; e.pc = p; e.sp = s; e.tag = tag;
    return e;
  endfunction

  // driver: one bus cycle = 2 clocks low + 2 clocks high; inputs held to the next fall
  task automatic bus_cycle(input logic [7:0] d, input logic st, input logic [7:0] opc,
                           input logic [15:0] pcv, input logic [7:0] spv, input exp_t e);
    exp_t lo;
    lo = e; lo.oe = 1'b0;
    @(negedge clk); phi2 = 1'b0;
    q.push_back(lo);
    @(negedge clk);
    din = d; start = st; opcode = opc; pc_in = pcv; sp_in = spv;
    -> smp;
    @(negedge clk); phi2 = 1'b1;
    q.push_back(e);
    @(negedge clk); -> smp;
  endtask

  task automatic idle_cycle(input logic st, input logic [7:0] opc, input logic [15:0] pcv,
                            input logic [7:0] spv, input string tag);
    bus_cycle(8'hFF, st, opc, pcv, spv, mk(model_pc, 1'b0, 1'b0, 8'h00, 1'b1, model_pc, model_sp, tag));
  endtask

  task automatic jsr_body(input logic [15:0] op, input logic [7:0] s, input logic [7:0] adl,
                          input logic [7:0] adh, input logic nst, input logic [15:0] npc, input logic [7:0] nsp);
    logic [15:0] a1, a2, tgt;
    a1 = op + 16'd1; a2 = op + 16'd2; tgt = {adh, adl};
    bus_cycle(adl,   1'b0, 8'h00, 16'h0, 8'h0, mk(a1, 1'b0, 1'b0, 8'h00, 1'b0, 16'h0, 8'h0, "R3"));
    bus_cycle(8'hA5, 1'b0, 8'h00, 16'h0, 8'h0, mk({8'h01, s}, 1'b0, 1'b0, 8'h00, 1'b0, 16'h0, 8'h0, "R4"));
    bus_cycle(8'h5A, 1'b0, 8'h00, 16'h0, 8'h0, mk({8'h01, s}, 1'b1, 1'b0, a2[15:8], 1'b0, 16'h0, 8'h0, "R5"));
    bus_cycle(8'h3C, 1'b0, 8'h00, 16'h0, 8'h0,
              mk({8'h01, 8'(s - 8'd1)}, 1'b1, 1'b0, a2[7:0], 1'b0, 16'h0, 8'h0, "R6"));
    bus_cycle(adh,   1'b0, 8'h00, 16'h0, 8'h0, mk(a2, 1'b0, 1'b0, 8'h00, 1'b0, 16'h0, 8'h0, "R7"));
    // R11: start inputs set during the closing fetch when nst is 1
    bus_cycle(8'hEE, nst, 8'h20, npc, nsp,
              mk(tgt, 1'b0, 1'b1, 8'h00, 1'b1, tgt, 8'(s - 8'd2), "R8"));
    model_pc = tgt;
    model_sp = 8'(s - 8'd2);
  endtask

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL R8 watchdog expired: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "addr", addr, 16'h0000);
    chk("R1", "rw_n", 16'(rw_n), 16'h1);
    chk("R1", "oe/sync/done", {13'h0, oe, sync, done}, 16'h0);
    chk("R1", "pc_o", pc_out, 16'h0000);
    chk("R1", "sp_o", 16'(sp_out), 16'h0000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: foreign opcode ignored, bus stays idle and pc unchanged
    idle_cycle(1'b1, 8'h4C, 16'h3333, 8'h77, "R1");
    idle_cycle(1'b0, 8'h00, 16'h0, 8'h0, "R2");
    // R2: call opcode accepted
    idle_cycle(1'b1, 8'h20, 16'h1000, 8'hFF, "R2");
    jsr_body(16'h1000, 8'hFF, 8'h34, 8'h12, 1'b0, 16'h0, 8'h0);
    idle_cycle(1'b0, 8'h00, 16'h0, 8'h0, "R8");

    // R10: stack pointer wrap and return address page carry
    idle_cycle(1'b1, 8'h20, 16'h12FE, 8'h00, "R10");
    jsr_body(16'h12FE, 8'h00, 8'hCD, 8'hAB, 1'b0, 16'h0, 8'h0);
    idle_cycle(1'b0, 8'h00, 16'h0, 8'h0, "R10");

    // R11: chained call out of the closing fetch
    idle_cycle(1'b1, 8'h20, 16'h2000, 8'h80, "R11");
    jsr_body(16'h2000, 8'h80, 8'h00, 8'h40, 1'b1, 16'h4000, 8'h7E);
    jsr_body(16'h4000, 8'h7E, 8'h99, 8'h88, 1'b0, 16'h0, 8'h0);
    idle_cycle(1'b0, 8'h00, 16'h0, 8'h0, "R11");

    repeat (4) @(negedge clk);
    chk("R8", "scoreboard drained", 16'(q.size()), 16'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule